// File: doc/BRIEF.md
# Main Clock Loss Detector

This block watches the main oscillator from a second, free-running reference clock and raises a reset request when the main clock has slowed below a floor of 100 kHz or has stopped. Every part of the decision lives in the reference domain. Only a small divider and toggle flop run on the main clock, so the request still forms and holds when the main clock is dead.

The main clock is first divided by a power of two. Each divided edge flips a toggle flop, and the toggle is synchronized into the reference domain, where every change counts as one divided edge. A window of a fixed number of reference cycles collects these counts. A window is marked failing when its count stays below a threshold, which is derived at elaboration from the reference frequency, the floor frequency, the window length and the divider.

The request is raised only after two consecutive windows fail. It stays raised while windows keep failing. Monitoring runs only while the software enable is set, crystal warm-up is not in progress and the part is not in deliberate stop mode. A sticky flag records each assertion of the request and is cleared only by a software clear pulse.

Top module: `clkmon_loss_det`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `fail_reset_req` and `fail_flag` are both 0.
- R2: A main clock comfortably above the floor, such as 200 kHz or 2 MHz, never raises `fail_reset_req` while monitoring is active.
- R3: A window lasts `WIN_CYC` reference cycles. It counts divided main edges, that is main rising edges divided by 2^`DIV_LOG2`. It fails when the count is below floor(`FLOOR_HZ`·`WIN_CYC`/(`REF_HZ`·2^`DIV_LOG2`)), which is 4 with the defaults. A 50 kHz main clock therefore raises the request within three windows.
- R4: Take a stopped main clock, with monitoring becoming active at reference edge 0. `fail_reset_req` is still 0 after edge 2·`WIN_CYC`−1 and is 1 after edge 2·`WIN_CYC`.
- R5: A single failing window that is followed by a passing window never raises `fail_reset_req`.
- R6: `fail_reset_req` stays 1 for as long as windows keep failing. It returns to 0 at the end of the first passing window.
- R7: Monitoring is active only when `sw_enable` is 1, `warmup_busy` is 0 and `stop_mode` is 0. While it is inactive the request stays 0 and the window and failure count restart. When monitoring resumes on a dead clock, the full R4 timing applies again.
- R8: If monitoring becomes inactive while `fail_reset_req` is 1, the request is 0 after the next reference edge.
- R9: `fail_flag` becomes 1 on the same reference edge on which `fail_reset_req` rises. It stays 1 after the request falls.
- R10: `fail_flag` is cleared only by a one-cycle pulse on `flag_clear`. It is 0 after the edge that samples the pulse, unless the request is rising on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Independent reference clock, which clocks all decision logic |
| rst_n | input | 1 | Asynchronous active-low block reset |
| main_clk | input | 1 | Main oscillator being monitored |
| sw_enable | input | 1 | Software enable for monitoring, which may change at any time |
| warmup_busy | input | 1 | 1 while the crystal warm-up period is running |
| stop_mode | input | 1 | 1 while the main clock is stopped on purpose |
| flag_clear | input | 1 | Software clear pulse for the sticky flag, in the reference domain |
| fail_reset_req | output | 1 | Reset request after two consecutive failing windows |
| fail_flag | output | 1 | Sticky record that a request was raised |

## Verification
The hardest situation to reach from the ports is a precisely placed sequence of windows. This includes the exact edge on which the second failing window completes, and a lone failing window followed directly by a passing one. The window phase is not visible at the ports. The stimulus therefore stops the main clock before monitoring is enabled, so the window boundaries follow from the enable edge. It then restarts the main clock just after the first boundary to produce exactly one dead window. The same aligned start is reused after releasing each gate, to show that the measurement restarted instead of resuming part way through.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    // Sources that may hold monitoring off
    typedef struct packed {
        logic enable;
        logic warmup;
        logic stopped;
    } gate_t;

    // Minimum divided-edge count a healthy window must reach (at least 1)
    function automatic int unsigned edge_threshold(
        input longint unsigned ref_hz,
        input longint unsigned floor_hz,
        input longint unsigned win_cyc,
        input longint unsigned div_log2
    );
        longint unsigned num;
        longint unsigned den;
        longint unsigned quo;
        num = floor_hz * win_cyc;
        den = ref_hz << div_log2;
        quo = num / den;
        if (quo == 0) quo = 1;
        return 32'(quo);
    endfunction

endpackage

// File: rtl/clkmon_div_toggle.sv
// Main-clock domain: divide by 2^DIV_LOG2 and flip a toggle once per divided edge
module clkmon_div_toggle #(
    parameter int unsigned DIV_LOG2 = 2
) (
    input  logic main_clk,
    input  logic rst_n,
    output logic tog_o
);

    generate
        if (DIV_LOG2 == 0) begin : g_direct
            logic tog_d, tog_q;

            always_comb begin
                tog_d = ~tog_q;
            end

            always_ff @(posedge main_clk or negedge rst_n) begin
                if (!rst_n) tog_q <= 1'b0;
                else        tog_q <= tog_d;
            end

            assign tog_o = tog_q;
        end else begin : g_div
            typedef struct packed {
                logic [DIV_LOG2-1:0] cnt;
                logic                tog;
            } div_st_t;

            div_st_t st_d, st_q;

            always_comb begin
                st_d     = st_q;
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.tog = st_q.tog ^ (&st_q.cnt);
            end

            always_ff @(posedge main_clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign tog_o = st_q.tog;
        end
    endgenerate

endmodule

// File: rtl/clkmon_sync.sv
// Multi-flop synchronizer into the reference domain
module clkmon_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] ff_d, ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb ff_d = d_i;
        end else begin : g_chain
            always_comb ff_d = {ff_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/clkmon_window.sv
// Reference-domain measurement window with a saturating edge count
module clkmon_window #(
    parameter int unsigned WIN_CYC = 1280,
    parameter int unsigned THR     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic edge_i,
    output logic end_o,
    output logic fail_o
);

    localparam int unsigned CNT_W  = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam int unsigned EDGE_W = $clog2(THR + 1);
    localparam logic [CNT_W-1:0]  LAST = CNT_W'(WIN_CYC - 1);
    localparam logic [EDGE_W-1:0] CAP  = EDGE_W'(THR);

    typedef struct packed {
        logic [CNT_W-1:0]  win;
        logic [EDGE_W-1:0] edges;
    } win_st_t;

    win_st_t           st_d, st_q;
    logic [EDGE_W-1:0] edge_sum;

    always_comb begin
        edge_sum = st_q.edges;
        if (edge_i && (st_q.edges != CAP)) edge_sum = st_q.edges + 1'b1;

        end_o  = run_i && (st_q.win == LAST);
        fail_o = end_o && (edge_sum < CAP);

        st_d = st_q;
        if (!run_i || end_o) begin
            st_d.win   = '0;
            st_d.edges = '0;
        end else begin
            st_d.win   = st_q.win + 1'b1;
            st_d.edges = edge_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the edge count never passes the threshold it is compared with
    p_edge_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.edges <= CAP);

    // R3: the window position stays inside one window
    p_win_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.win <= LAST);

    // R7: a held-off window starts again from its first cycle
    p_idle_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q.win == '0));

endmodule

// File: rtl/clkmon_loss_det.sv
// Top: main clock loss detector, decision logic clocked by ref_clk only
module clkmon_loss_det #(
    parameter int unsigned REF_HZ      = 8_000_000,
    parameter int unsigned FLOOR_HZ    = 100_000,
    parameter int unsigned WIN_CYC     = 1280,
    parameter int unsigned DIV_LOG2    = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FAIL_RUNS   = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic main_clk,
    input  logic sw_enable,
    input  logic warmup_busy,
    input  logic stop_mode,
    input  logic flag_clear,
    output logic fail_reset_req,
    output logic fail_flag
);

    import clkmon_pkg::*;

    localparam int unsigned THR   = edge_threshold(REF_HZ, FLOOR_HZ, WIN_CYC, DIV_LOG2);
    localparam int unsigned RUN_W = $clog2(FAIL_RUNS + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(FAIL_RUNS);

    typedef struct packed {
        logic             tog_prev;
        logic [RUN_W-1:0] runs;
        logic             req;
        logic             flag;
    } mon_st_t;

    mon_st_t st_d, st_q;
    gate_t   gate;
    logic    active;
    logic    tog_main;
    logic    tog_sync;
    logic    edge_seen;
    logic    win_end;
    logic    win_fail;

    clkmon_div_toggle #(.DIV_LOG2(DIV_LOG2)) div_i (
        .main_clk (main_clk),
        .rst_n    (rst_n),
        .tog_o    (tog_main)
    );

    clkmon_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d_i   (tog_main),
        .q_o   (tog_sync)
    );

    clkmon_window #(.WIN_CYC(WIN_CYC), .THR(THR)) win_i (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .run_i  (active),
        .edge_i (edge_seen),
        .end_o  (win_end),
        .fail_o (win_fail)
    );

    always_comb begin
        gate      = '{enable: sw_enable, warmup: warmup_busy, stopped: stop_mode};
        active    = gate.enable && !gate.warmup && !gate.stopped;
        edge_seen = tog_sync ^ st_q.tog_prev;

        st_d          = st_q;
        st_d.tog_prev = tog_sync;

        if (!active) begin
            st_d.runs = '0;
        end else if (win_end) begin
            if (!win_fail)               st_d.runs = '0;
            else if (st_q.runs != RUN_MAX) st_d.runs = st_q.runs + 1'b1;
        end

        st_d.req  = active && (st_d.runs == RUN_MAX);
        st_d.flag = (st_q.flag && !flag_clear) || (st_d.req && !st_q.req);
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fail_reset_req = st_q.req;
    assign fail_flag      = st_q.flag;

    // R4: the request only rises right after a failing window closes
    p_req_after_fail_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(st_q.req) |-> $past(win_fail));

    // R8: a held-off monitor drops the request on the next edge
    p_gate_drops_req_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!sw_enable || warmup_busy || stop_mode) |=> !fail_reset_req);

    // R9: the flag is up whenever the request has just risen
    p_flag_with_req_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(fail_reset_req) |-> fail_flag);

    // R9: the flag only rises together with the request
    p_flag_source_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(fail_flag) |-> $rose(fail_reset_req));

    // R10: without a clear pulse the flag holds
    p_flag_sticky_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (fail_flag && !flag_clear) |=> fail_flag);

endmodule

// File: tb/clkmon_loss_det_tb.sv
`timescale 1ns/1ps
module clkmon_loss_det_tb_top;

    localparam real REF_PERIOD_NS = 125.0;
    localparam int  WIN           = 1280;

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic main_clk = 1'b0;
    logic sw_enable = 1'b0;
    logic warmup_busy = 1'b0;
    logic stop_mode = 1'b0;
    logic flag_clear = 1'b0;
    logic fail_reset_req;
    logic fail_flag;

    real main_half_ns = 250.0;
    bit  main_run     = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    clkmon_loss_det #(
        .REF_HZ(8_000_000), .FLOOR_HZ(100_000), .WIN_CYC(WIN),
        .DIV_LOG2(2), .SYNC_STAGES(2), .FAIL_RUNS(2)
    ) dut_i (
        .ref_clk        (ref_clk),
        .rst_n          (rst_n),
        .main_clk       (main_clk),
        .sw_enable      (sw_enable),
        .warmup_busy    (warmup_busy),
        .stop_mode      (stop_mode),
        .flag_clear     (flag_clear),
        .fail_reset_req (fail_reset_req),
        .fail_flag      (fail_flag)
    );

    always #(REF_PERIOD_NS / 2.0) ref_clk = ~ref_clk;

    initial begin
        forever begin
            #(main_half_ns);
            if (main_run) main_clk = ~main_clk;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge ref_clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Count cycles with the request high over n cycles
    task automatic req_highs(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (fail_reset_req) highs++;
        end
    endtask

    task automatic pulse_clear();
        flag_clear = 1'b1;
        step(1);
        flag_clear = 1'b0;
    endtask

    task automatic set_main(input bit run, input real half_ns);
        main_half_ns = half_ns;
        main_run     = run;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(5);
        chk("R1 req in reset", fail_reset_req, 0);
        chk("R1 flag in reset", fail_flag, 0);
        rst_n = 1'b1;
        step(3);
        chk("R1 req after reset", fail_reset_req, 0);
        chk("R1 flag after reset", fail_flag, 0);
    endtask

    task automatic t_healthy();
        int h;
        set_main(1, 250.0);
        step(20);
        sw_enable = 1'b1;
        req_highs(4 * WIN, h);
        chk("R2 2MHz no request", h, 0);
        set_main(1, 2500.0);
        req_highs(4 * WIN, h);
        chk("R2 200kHz no request", h, 0);
        chk("R2 flag untouched", fail_flag, 0);
        sw_enable = 1'b0;
        step(5);
    endtask

    task automatic t_dead();
        int h;
        set_main(0, 250.0);
        step(20);
        sw_enable = 1'b1;
        step(2 * WIN - 1);
        chk("R4 low before second window end", fail_reset_req, 0);
        step(1);
        chk("R4 high at second window end", fail_reset_req, 1);
        chk("R9 flag with request", fail_flag, 1);
        req_highs(3 * WIN, h);
        chk("R6 held while failing", h, 3 * WIN);
        set_main(1, 250.0);
        step(2 * WIN + 10);
        chk("R6 released after passing window", fail_reset_req, 0);
        chk("R9 flag sticky after release", fail_flag, 1);
        step(WIN);
        chk("R10 flag holds without clear", fail_flag, 1);
        pulse_clear();
        chk("R10 flag cleared by pulse", fail_flag, 0);
        sw_enable = 1'b0;
        step(5);
    endtask

    task automatic t_slow();
        set_main(1, 10000.0);
        step(20);
        sw_enable = 1'b1;
        step(3 * WIN + 5);
        chk("R3 50kHz raises request", fail_reset_req, 1);
        sw_enable = 1'b0;
        step(2);
        pulse_clear();
        chk("R10 flag cleared after slow test", fail_flag, 0);
    endtask

    task automatic t_single();
        int h;
        set_main(0, 250.0);
        step(20);
        sw_enable = 1'b1;
        step(WIN + 4);
        set_main(1, 250.0);
        req_highs(4 * WIN, h);
        chk("R5 single failing window rejected", h, 0);
        chk("R5 flag untouched", fail_flag, 0);
        sw_enable = 1'b0;
        step(5);
    endtask

    // which: 0 = enable low, 1 = warm-up, 2 = stop mode
    task automatic t_gate(input int which);
        int h;
        set_main(0, 250.0);
        step(20);
        sw_enable   = (which != 0);
        warmup_busy = (which == 1);
        stop_mode   = (which == 2);
        req_highs(3 * WIN, h);
        chk($sformatf("R7 gated no request (gate %0d)", which), h, 0);
        chk($sformatf("R7 gated no flag (gate %0d)", which), fail_flag, 0);
        sw_enable   = 1'b1;
        warmup_busy = 1'b0;
        stop_mode   = 1'b0;
        step(2 * WIN - 1);
        chk($sformatf("R7 restart low (gate %0d)", which), fail_reset_req, 0);
        step(1);
        chk($sformatf("R7 restart high (gate %0d)", which), fail_reset_req, 1);
        step(WIN / 2);
        sw_enable   = (which != 0);
        warmup_busy = (which == 1);
        stop_mode   = (which == 2);
        step(1);
        chk($sformatf("R8 gate drops request (gate %0d)", which), fail_reset_req, 0);
        chk($sformatf("R9 flag survives gate (gate %0d)", which), fail_flag, 1);
        sw_enable   = 1'b0;
        warmup_busy = 1'b0;
        stop_mode   = 1'b0;
        pulse_clear();
        chk($sformatf("R10 flag cleared (gate %0d)", which), fail_flag, 0);
    endtask

    initial begin
        #(REF_PERIOD_NS * 190000.0);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_healthy();
        t_dead();
        t_slow();
        t_single();
        for (int g = 0; g < 3; g++) t_gate(g);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule